// File: doc/BRIEF.md
# Once-Per-Second Interrupt Generator

This block turns a 64 Hz tick-enable into one event per second and uses that event to raise a sticky seconds flag and an interrupt line. The tick arrives as a one-cycle strobe on the system clock. A 6-bit divider counts the strobes and fires when it wraps from 63 back to 0. The event stands for the seconds count advancing. The block does not depend on any other timer in the device.

The interrupt has two modes, chosen by a mode bit. In pulse mode the line goes high for exactly one 64 Hz period after each event. In level mode the line follows the seconds flag, so it stays high until the host clears the flag. The flag cannot clear itself. Only the host clear strobe lowers it.

When the enable bit is low, the divider is held at zero, no event occurs and the interrupt line stays low. Re-enabling therefore starts a fresh full second.

Top module: `sec_irq_gen`

## Requirements
- R1: While reset is active and on the first cycle after it, `sec_flag_o` and `irq_o` are 0 and the divider is at 0.
- R2: While `enable_i` is 1, an event fires on the cycle that carries the 64th `tick_i` strobe since the divider was last at 0. `sec_flag_o` is 1 on the following cycle. Cycles without `tick_i` do not advance the divider.
- R3: `sec_flag_o` is sticky. A new event never lowers it, and it falls only on the cycle after `flag_clr_i` was 1 with no event in the same cycle.
- R4: If `flag_clr_i` and an event occur in the same cycle, `sec_flag_o` is 1 afterwards.
- R5: While `enable_i` is 0, the divider is forced to 0, `sec_flag_o` cannot become set, and `irq_o` is 0.
- R6: After `enable_i` returns to 1, the first event needs a full 64 ticks, no matter what the count was when the block was disabled.
- R7: With `pulse_mode_i` = 1 (pulse mode) and `enable_i` = 1, `irq_o` rises on the cycle after an event. It falls on the cycle after the next `tick_i`, so the pulse lasts one tick period. It ignores the state of `sec_flag_o`.
- R8: With `pulse_mode_i` = 0 (level mode) and `enable_i` = 1, `irq_o` equals `sec_flag_o`.

Ports are listed in the order of the module's port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Generator on (1) / off (0) |
| pulse_mode_i | input | 1 | 1 = pulse interrupt, 0 = level interrupt |
| flag_clr_i | input | 1 | One-cycle host strobe that clears the seconds flag |
| tick_i | input | 1 | One-cycle 64 Hz tick-enable strobe |
| sec_flag_o | output | 1 | Sticky seconds flag |
| irq_o | output | 1 | Interrupt output |

## Verification
The hardest case to reach from the ports is a host clear landing on the exact cycle of an event. That cycle only comes around once every 64 ticks, and only when the divider is at its last count. The bench drives a reference count of its own alongside the design. Whenever that count reaches 63, it raises `flag_clr_i` together with the tick, and it does this in both modes. The bench also disables the block partway through a second and re-enables it. This shows that the leftover count is thrown away.

// File: rtl/sec_irq_pkg.sv
package sec_irq_pkg;

    // Interrupt signalling mode, as selected by pulse_mode_i
    typedef enum logic {
        IRQ_LEVEL = 1'b0,
        IRQ_PULSE = 1'b1
    } irq_mode_e;

    // Registered state of the flag keeper
    typedef struct packed {
        logic flag;
    } flag_state_t;

    // Registered state of the pulse stretcher
    typedef struct packed {
        logic pulse;
    } pulse_state_t;

endpackage

// File: rtl/sec_tick_divider.sv
module sec_tick_divider #(
    parameter int DIV_BITS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic tick_i,
    output logic event_o
);
    localparam logic [DIV_BITS-1:0] CNT_LAST = {DIV_BITS{1'b1}};

    typedef struct packed {
        logic [DIV_BITS-1:0] cnt;
    } div_state_t;

    div_state_t state_d, state_q;
    logic       wrap;

    always_comb begin
        state_d = state_q;
        wrap    = 1'b0;
        if (!enable_i) begin
            state_d.cnt = '0;
        end else if (tick_i) begin
            wrap        = (state_q.cnt == CNT_LAST);
            state_d.cnt = state_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign event_o = wrap;
endmodule

// File: rtl/sec_flag_keeper.sv
module sec_flag_keeper
    import sec_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    flag_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (set_i)      state_d.flag = 1'b1;
        else if (clr_i) state_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign flag_o = state_q.flag;
endmodule

// File: rtl/sec_pulse_stretch.sv
module sec_pulse_stretch
    import sec_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic start_i,
    input  logic tick_i,
    output logic pulse_o
);
    pulse_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (!enable_i)   state_d.pulse = 1'b0;
        else if (start_i) state_d.pulse = 1'b1;
        else if (tick_i)  state_d.pulse = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign pulse_o = state_q.pulse;
endmodule

// File: rtl/sec_irq_gen.sv
module sec_irq_gen
    import sec_irq_pkg::*;
#(
    parameter int DIV_BITS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic pulse_mode_i,
    input  logic flag_clr_i,
    input  logic tick_i,
    output logic sec_flag_o,
    output logic irq_o
);
    logic      sec_event;
    logic      pulse_q;
    irq_mode_e mode;

    sec_tick_divider #(.DIV_BITS(DIV_BITS)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (enable_i),
        .tick_i   (tick_i),
        .event_o  (sec_event)
    );

    sec_flag_keeper u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (sec_event),
        .clr_i  (flag_clr_i),
        .flag_o (sec_flag_o)
    );

    sec_pulse_stretch u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (enable_i),
        .start_i  (sec_event),
        .tick_i   (tick_i),
        .pulse_o  (pulse_q)
    );

    always_comb begin
        mode  = irq_mode_e'(pulse_mode_i);
        irq_o = 1'b0;
        if (enable_i) begin
            irq_o = (mode == IRQ_PULSE) ? pulse_q : sec_flag_o;
        end
    end
endmodule

// File: rtl/sec_irq_gen_chk.sv
module sec_irq_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic enable_i,
    input logic pulse_mode_i,
    input logic flag_clr_i,
    input logic tick_i,
    input logic sec_flag_o,
    input logic irq_o
);
    // R2
    flag_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sec_flag_o) |-> $past(tick_i && enable_i));

    // R3
    flag_fall_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sec_flag_o) |-> $past(flag_clr_i));

    // R5
    no_set_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable_i) |-> !$rose(sec_flag_o));

    // R5
    quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |-> !irq_o);

    // R8
    level_follows_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && !pulse_mode_i) |-> (irq_o == sec_flag_o));

    // R7
    pulse_ends_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(irq_o) && enable_i && pulse_mode_i && $past(enable_i && pulse_mode_i))
        |-> $past(tick_i));
endmodule

bind sec_irq_gen sec_irq_gen_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable_i     (enable_i),
    .pulse_mode_i (pulse_mode_i),
    .flag_clr_i   (flag_clr_i),
    .tick_i       (tick_i),
    .sec_flag_o   (sec_flag_o),
    .irq_o        (irq_o)
);

// File: tb/sec_irq_gen_bench.sv
module sec_irq_gen_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable_i = 1'b0, pulse_mode_i = 1'b0, flag_clr_i = 1'b0, tick_i = 1'b0;
    logic sec_flag_o, irq_o;

    int errors = 0;
    int checks = 0;

    typedef struct {
        logic  flag;
        logic  irq;
        string req;
    } exp_t;
    exp_t sb[$];

    // reference model state
    int   m_cnt = 0;
    logic m_flag = 1'b0;
    logic m_pulse = 1'b0;

    always #5 clk = ~clk;

    sec_irq_gen u_sec_irq_gen (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .pulse_mode_i(pulse_mode_i),
        .flag_clr_i(flag_clr_i), .tick_i(tick_i), .sec_flag_o(sec_flag_o), .irq_o(irq_o)
    );

    task automatic check(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // driver: one cycle of stimulus plus the expected outcome
    task automatic step(input logic en, input logic mode, input logic clr,
                        input logic tk, input string req);
        logic ev;
        exp_t e;
        @(negedge clk);
        enable_i = en; pulse_mode_i = mode; flag_clr_i = clr; tick_i = tk;
        ev = en && tk && (m_cnt == 63);
        if (!en)     m_cnt = 0;
        else if (tk) m_cnt = (m_cnt + 1) % 64;
        if (ev)       m_flag = 1'b1;
        else if (clr) m_flag = 1'b0;
        if (!en)      m_pulse = 1'b0;
        else if (ev)  m_pulse = 1'b1;
        else if (tk)  m_pulse = 1'b0;
        e.flag = m_flag;
        e.irq  = en && (mode ? m_pulse : m_flag);
        e.req  = req;
        sb.push_back(e);
    endtask

    // run n cycles, tick on every other cycle; optional clear on the event tick
    task automatic run(input int n, input logic en, input logic mode,
                       input logic clr_on_event, input string req);
        for (int i = 0; i < n; i++) begin
            logic tk;
            tk = (i % 2 == 0);
            step(en, mode, clr_on_event && tk && en && (m_cnt == 63), tk, req);
        end
    endtask

    // monitor: pop and compare after every clock edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(sec_flag_o, e.flag, e.req, "sec_flag_o");
                check(irq_o, e.irq, e.req, "irq_o");
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check(sec_flag_o, 1'b0, "R1", "flag in reset");
        check(irq_o, 1'b0, "R1", "irq in reset");
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 1'b0, 1'b0, "R1");
        // R2 / R8: level mode, first second from a zero divider
        run(140, 1'b1, 1'b0, 1'b0, "R2");
        run(10, 1'b1, 1'b0, 1'b0, "R8");
        // R3: clear in a quiet cycle, and a second event with flag already set
        step(1'b1, 1'b0, 1'b1, 1'b0, "R3");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R3");
        run(128, 1'b1, 1'b0, 1'b0, "R3");
        run(128, 1'b1, 1'b0, 1'b0, "R3");
        step(1'b1, 1'b0, 1'b1, 1'b0, "R3");
        // R4: clear coincident with an event, level then pulse mode
        run(140, 1'b1, 1'b0, 1'b1, "R4");
        run(140, 1'b1, 1'b1, 1'b1, "R4");
        // R7: pulse mode over two seconds, flag left set
        run(260, 1'b1, 1'b1, 1'b0, "R7");
        // R5: stop mid-second, ticks keep coming
        run(60, 1'b1, 1'b0, 1'b0, "R5");
        step(1'b1, 1'b0, 1'b1, 1'b0, "R5");
        run(300, 1'b0, 1'b0, 1'b0, "R5");
        run(20, 1'b0, 1'b1, 1'b0, "R5");
        // R6: restart needs a full 64 ticks
        run(140, 1'b1, 1'b0, 1'b0, "R6");
        run(140, 1'b1, 1'b1, 1'b0, "R7");
        repeat (3) @(posedge clk);
        #3;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule